// File: doc/BRIEF.md
# I2C Master START Generator with Collision Detection

This block drives the START condition of an I2C master onto open-drain SDA and SCL lines. Software sets a start request. The block then checks that both lines are free. It runs two timed phases from its own down-counting baud timer. At the end of the first phase it pulls SDA low, and at the end of the second it pulls SCL low. Both lines are sampled through a two-flop synchronizer, and the outputs are active-high pull-low enables. The bus is a wired-AND of these drives with external pull-ups.

A line found low before the sequence starts is a bus collision, and so is SCL low while SDA is still high in the first phase. Either one aborts the sequence. SDA pulled low early by another master is not a collision: it only cuts the first phase short. SCL low during the second phase is ignored. Collision and interrupt flags stay set until a clear input is pulsed. After a completed START, both drives stay asserted until the next accepted request releases them.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, sda_pull, scl_pull, start_en, start_seen, irq_flag and bcol_flag are all 0.
- R2: A request accepted in idle sets start_en and releases both drives. Three cycles later both synchronized lines are checked. If either is low, the block sets bcol_flag and irq_flag, clears start_en, leaves both drives off and returns to idle.
- R3: If both lines are high at the check, sda_pull rises N cycles after the check. N is the reload value, or 1 when the reload value is 0.
- R4: If SCL is low while SDA is high during the first phase, the block aborts. It sets bcol_flag and irq_flag, clears start_en and leaves sda_pull off. The abort is registered three clock edges after the line change.
- R5: If SDA is low during the first phase, this is not a collision. sda_pull rises three edges after the line falls, and the second phase starts from there.
- R6: scl_pull rises N cycles after sda_pull, even if SCL is low during that phase. In the same cycle, start_en clears and irq_flag is set.
- R7: bcol_flag, irq_flag and start_seen stay set until flag_clr is pulsed. They read 0 on the cycle after the pulse. Setting a flag takes priority over clearing it.
- R8: start_seen is set when the synchronized SDA falls while the synchronized SCL is high.
- R9: A request made while a sequence is running is ignored. The timing of the running sequence does not change.
- R10: After a completed START, both drives stay asserted until the next accepted request, which releases them in the cycle it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_set | input | 1 | START request, sampled only in idle |
| reload | input | RW (7) | Baud timer reload value |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_in | input | 1 | SCL line level (asynchronous) |
| flag_clr | input | 1 | Clears the sticky flags |
| sda_pull | output | 1 | Pull SDA low when 1 |
| scl_pull | output | 1 | Pull SCL low when 1 |
| start_en | output | 1 | Request pending or sequence running |
| start_seen | output | 1 | START seen on the bus (sticky) |
| irq_flag | output | 1 | Set on completion or on a collision abort (sticky) |
| bcol_flag | output | 1 | Bus collision (sticky) |

## Verification
Take the edge that accepts a request as E0. The line check happens at E3. With the reload at N, sda_pull changes at E(3+N) and scl_pull at E(3+2N). A line change on the bus reaches the state logic three edges later, so an abort, or an early SDA drive, is registered at the third edge after the bench moves the line. The bench drives inputs and samples outputs on falling edges and counts rising edges from E0. Each timed result is checked on the cycle before it is due, where the output must still hold its old value, and on the cycle where it is due, where the output must have changed.

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
  parameter int RW   = 7,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_set,
  input  logic [RW-1:0] reload,
  input  logic          sda_in,
  input  logic          scl_in,
  input  logic          flag_clr,
  output logic          sda_pull,
  output logic          scl_pull,
  output logic          start_en,
  output logic          start_seen,
  output logic          irq_flag,
  output logic          bcol_flag
);

  localparam int SETTLE_N = SYNC + 1;
  localparam int SW       = $clog2(SETTLE_N + 1);
  localparam int CW       = (RW > SW) ? RW : SW;

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_PH1, S_PH2} state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic [SYNC-1:0] sda_sh, scl_sh;
  logic            sda_s, scl_s, sda_q;
  logic            abort_c, done_c, last_c;
  logic [CW-1:0]   n_load;

  assign sda_s  = sda_sh[SYNC-1];
  assign scl_s  = scl_sh[SYNC-1];
  assign last_c = (cnt == CW'(1));
  assign n_load = (reload == '0) ? CW'(1) : CW'(reload);

  assign abort_c = ((st == S_SETTLE) && last_c && (!sda_s || !scl_s)) ||
                   ((st == S_PH1) && sda_s && !scl_s);
  assign done_c  = (st == S_PH2) && last_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sh <= '1;
      scl_sh <= '1;
      sda_q  <= 1'b1;
    end else begin
      sda_sh <= {sda_sh[SYNC-2:0], sda_in};
      scl_sh <= {scl_sh[SYNC-2:0], scl_in};
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sda_pull <= 1'b0;
      scl_pull <= 1'b0;
      start_en <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_set) begin
            st       <= S_SETTLE;
            cnt      <= CW'(SETTLE_N);
            sda_pull <= 1'b0;
            scl_pull <= 1'b0;
            start_en <= 1'b1;
          end
        end
        S_SETTLE: begin
          if (abort_c) begin
            st       <= S_IDLE;
            start_en <= 1'b0;
          end else if (last_c) begin
            st  <= S_PH1;
            cnt <= n_load;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_PH1: begin
          if (abort_c) begin
            st       <= S_IDLE;
            start_en <= 1'b0;
          end else if (!sda_s || last_c) begin
            sda_pull <= 1'b1;
            st       <= S_PH2;
            cnt      <= n_load;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_PH2: begin
          if (last_c) begin
            scl_pull <= 1'b1;
            start_en <= 1'b0;
            st       <= S_IDLE;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcol_flag  <= 1'b0;
      irq_flag   <= 1'b0;
      start_seen <= 1'b0;
    end else begin
      if (abort_c)       bcol_flag <= 1'b1;
      else if (flag_clr) bcol_flag <= 1'b0;
      if (abort_c || done_c) irq_flag <= 1'b1;
      else if (flag_clr)     irq_flag <= 1'b0;
      if (sda_q && !sda_s && scl_s) start_seen <= 1'b1;
      else if (flag_clr)            start_seen <= 1'b0;
    end
  end

  p_scl_after_sda_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> sda_pull && !start_en && irq_flag);

  p_abort_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bcol_flag) |-> !start_en && !sda_pull && !scl_pull && irq_flag);

  p_bcol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bcol_flag && !flag_clr |=> bcol_flag);

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !flag_clr |=> irq_flag);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> !(st == S_SETTLE && cnt == CW'(SETTLE_N)));

  p_phase_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PH1 || st == S_PH2) |-> cnt != '0);

  p_ph2_no_collision_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PH2) |=> !$rose(bcol_flag));

endmodule

// File: tb/tb_i2c_start_gen.sv
module tb_i2c_start_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_set = 1'b0;
  logic [6:0] reload = '0;
  logic flag_clr = 1'b0;
  logic ext_sda = 1'b0, ext_scl = 1'b0;
  logic sda_pull, scl_pull, start_en, start_seen, irq_flag, bcol_flag;
  logic sda_in, scl_in;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  assign sda_in = ~(sda_pull | ext_sda);
  assign scl_in = ~(scl_pull | ext_scl);

  i2c_start_gen dut (
    .clk(clk), .rst_n(rst_n), .start_set(start_set), .reload(reload),
    .sda_in(sda_in), .scl_in(scl_in), .flag_clr(flag_clr),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .start_en(start_en),
    .start_seen(start_seen), .irq_flag(irq_flag), .bcol_flag(bcol_flag));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request();
    start_set = 1'b1;
    adv(1);
    start_set = 1'b0;
  endtask

  task automatic clear_flags(input string req);
    flag_clr = 1'b1;
    adv(1);
    flag_clr = 1'b0;
    chk(req, "bcol cleared", bcol_flag, 1'b0);
    chk(req, "irq cleared", irq_flag, 1'b0);
    chk(req, "seen cleared", start_seen, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1", "sda_pull", sda_pull, 1'b0);
    chk("R1", "scl_pull", scl_pull, 1'b0);
    chk("R1", "start_en", start_en, 1'b0);
    chk("R1", "start_seen", start_seen, 1'b0);
    chk("R1", "irq", irq_flag, 1'b0);
    chk("R1", "bcol", bcol_flag, 1'b0);
  endtask

  task automatic t_normal(input int rv);
    int n;
    n = (rv == 0) ? 1 : rv;
    reload = 7'(rv);
    request();
    chk("R10", "sda released", sda_pull, 1'b0);
    chk("R10", "scl released", scl_pull, 1'b0);
    chk("R2", "start_en set", start_en, 1'b1);
    adv(2 + n);
    chk("R3", "sda before due", sda_pull, 1'b0);
    adv(1);
    chk("R3", "sda due", sda_pull, 1'b1);
    chk("R3", "start_en held", start_en, 1'b1);
    adv(n - 1);
    chk("R6", "scl before due", scl_pull, 1'b0);
    adv(1);
    chk("R6", "scl due", scl_pull, 1'b1);
    chk("R6", "start_en cleared", start_en, 1'b0);
    chk("R6", "irq set", irq_flag, 1'b1);
    chk("R6", "no collision", bcol_flag, 1'b0);
    adv(3);
    chk("R8", "start seen", start_seen, 1'b1);
    chk("R10", "sda held", sda_pull, 1'b1);
    chk("R10", "scl held", scl_pull, 1'b1);
    clear_flags("R7");
  endtask

  task automatic t_pre_abort(input logic on_sda);
    ext_sda = on_sda;
    ext_scl = !on_sda;
    reload = 7'd5;
    adv(3);
    request();
    adv(2);
    chk("R2", "start_en before check", start_en, 1'b1);
    chk("R2", "no bcol before check", bcol_flag, 1'b0);
    adv(1);
    chk("R2", "bcol at check", bcol_flag, 1'b1);
    chk("R2", "irq at check", irq_flag, 1'b1);
    chk("R2", "start_en cleared", start_en, 1'b0);
    chk("R2", "no sda drive", sda_pull, 1'b0);
    chk("R2", "no scl drive", scl_pull, 1'b0);
    adv(5);
    chk("R7", "bcol sticky", bcol_flag, 1'b1);
    chk("R2", "still no sda drive", sda_pull, 1'b0);
    ext_sda = 1'b0;
    ext_scl = 1'b0;
    adv(3);
    clear_flags("R7");
  endtask

  task automatic t_ph1_collision();
    reload = 7'd10;
    request();
    adv(5);
    ext_scl = 1'b1;
    adv(2);
    chk("R4", "no bcol yet", bcol_flag, 1'b0);
    adv(1);
    chk("R4", "bcol", bcol_flag, 1'b1);
    chk("R4", "irq", irq_flag, 1'b1);
    chk("R4", "start_en cleared", start_en, 1'b0);
    chk("R4", "sda not driven", sda_pull, 1'b0);
    adv(10);
    chk("R4", "sda stays off", sda_pull, 1'b0);
    ext_scl = 1'b0;
    adv(3);
    clear_flags("R7");
  endtask

  task automatic t_early_sda();
    reload = 7'd10;
    request();
    adv(5);
    ext_sda = 1'b1;
    adv(2);
    chk("R5", "sda not yet", sda_pull, 1'b0);
    adv(1);
    chk("R5", "sda early", sda_pull, 1'b1);
    chk("R5", "no collision", bcol_flag, 1'b0);
    adv(9);
    chk("R5", "scl before due", scl_pull, 1'b0);
    adv(1);
    chk("R5", "scl due", scl_pull, 1'b1);
    chk("R5", "no collision end", bcol_flag, 1'b0);
    chk("R8", "start seen", start_seen, 1'b1);
    ext_sda = 1'b0;
    adv(1);
    clear_flags("R7");
  endtask

  task automatic t_ph2_scl();
    reload = 7'd6;
    request();
    adv(10);
    chk("R6", "sda driven", sda_pull, 1'b1);
    ext_scl = 1'b1;
    adv(4);
    chk("R6", "scl before due", scl_pull, 1'b0);
    chk("R6", "no collision", bcol_flag, 1'b0);
    adv(1);
    chk("R6", "scl due", scl_pull, 1'b1);
    chk("R6", "no collision end", bcol_flag, 1'b0);
    ext_scl = 1'b0;
    adv(2);
    clear_flags("R7");
  endtask

  task automatic t_busy();
    reload = 7'd8;
    request();
    adv(4);
    start_set = 1'b1;
    adv(1);
    start_set = 1'b0;
    adv(5);
    chk("R9", "sda before due", sda_pull, 1'b0);
    adv(1);
    chk("R9", "sda due", sda_pull, 1'b1);
    adv(7);
    chk("R9", "scl before due", scl_pull, 1'b0);
    adv(1);
    chk("R9", "scl due", scl_pull, 1'b1);
    adv(3);
    clear_flags("R7");
  endtask

  task automatic t_set_priority();
    ext_sda = 1'b1;
    reload = 7'd3;
    adv(3);
    request();
    adv(2);
    flag_clr = 1'b1;
    adv(1);
    flag_clr = 1'b0;
    chk("R7", "set wins over clear", bcol_flag, 1'b1);
    ext_sda = 1'b0;
    adv(3);
    clear_flags("R7");
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    adv(3);
    rst_n = 1'b1;
    adv(2);
    t_reset();
    t_normal(10);
    t_normal(0);
    t_normal(3);
    t_pre_abort(1'b1);
    t_pre_abort(1'b0);
    t_ph1_collision();
    t_early_sda();
    t_ph2_scl();
    t_busy();
    t_set_priority();
    t_normal(127);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule